// File: doc/BRIEF.md
# Quad-lane continuous read engine with burst wrap

This block is the device-side read path of a serial flash that answers the two quad-lane read opcodes, EBh and E7h. The host drives chip select (active low), a serial clock and up to four data lanes. The block samples all three in its own system clock and detects the serial clock edges there. The opcode arrives one bit per serial clock on lane 0. The 24-bit address and an 8-bit mode byte arrive four bits per serial clock. A number of dummy clocks follows, and after them the addressed bytes go out four bits per serial clock, high nibble first. The byte array sits behind a memory port with one cycle of read latency. A quad-enable bit taken from the status register gates both quad opcodes.

The mode byte can put the block into a continuous state that lasts across chip-select cycles. While that state is active, the next transaction skips the opcode and starts straight with the address. A separate single-lane opcode, 77h, loads a wrap setting. With wrap enabled, each read stays inside an aligned 8, 16, 32 or 64-byte window of the address: the low address bits count around and the upper bits do not move.

Top module: `qrd_quad_read_engine`

## Requirements
- R1: After reset the lane drivers are off (`io_oe` = 0), continuous mode is off so the first transaction must carry an opcode, and wrap is off.
- R2: Opcode EBh (8 serial clocks, lane 0, MSB first), when honoured, is followed by 6 address nibbles (MSB first), 2 mode nibbles (high first) and 4 dummy clocks. From the first falling serial clock edge after the last dummy clock, the data nibbles are driven high nibble first with `io_oe` = 4'hF.
- R3: Opcode E7h behaves like EBh except that it has 2 dummy clocks and address bit 0 is taken as 0.
- R4: With wrap off, the read address rises by one after each byte. It crosses 256-byte page boundaries and rolls from the top of the 24-bit space to 0.
- R5: A mode byte whose upper nibble is 4'hA makes the next transaction, after chip select rises and falls, start directly with the address. That transaction uses the same command kind (EBh or E7h) that set the mode.
- R6: A mode byte with any other upper nibble, including one sent during a transaction without an opcode, makes the next transaction require the opcode again.
- R7: With the quad-enable input at 0, EBh and E7h are ignored: the lanes stay undriven until chip select rises, and the continuous state is left unchanged.
- R8: Opcode 77h (lane 0) is followed by 24 ignored bits and then a wrap byte, MSB first. Bits 6:4 of that byte are loaded as the wrap setting whatever the quad-enable input is.
- R9: With wrap bit 4 = 0, bits 6:5 = 00, 01, 10, 11 give windows of 8, 16, 32, 64 bytes. The address counts modulo the window length in its low bits while all higher bits stay fixed. This applies to both EBh and E7h.
- R10: Loading a wrap byte with bit 4 = 1 turns wrap off, and reads go back to linear addressing.
- R11: Any other opcode is ignored: no lane is driven until chip select rises.
- R12: `io_oe` is always 4'h0 or 4'hF, and is 4'h0 once chip select has been high for more than 4 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic and sampling run on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host; inputs taken on its rising edge, outputs changed on its falling edge |
| io_in | input | LANES (4) | Lane input values; lane 0 carries single-lane bits |
| io_out | output | LANES (4) | Lane output values during the data phase |
| io_oe | output | LANES (4) | Lane output enables |
| qe | input | 1 | Quad-enable bit from the status register |
| mem_addr | output | ADDR_W (24) | Byte address to the memory array |
| mem_rdata | input | BYTE_W (8) | Byte read back, valid one clock after `mem_addr` |

## Verification
The bench builds the block with its default parameters: a 24-bit address, four lanes, 4 and 2 dummy clocks and two synchronizer stages. The full address width lets a read start at 0xFFFFFE and show the rollover to 0, and it makes every wrap length from 8 to 64 bytes, and the crossing of page boundaries, reachable with direct addresses. The serial clock half period of 8 system clocks covers the synchronizer and output latency. This lets the bench sample each nibble just before the rising edge that follows it, and compare it with a behavioural model of the address sequence, wrap setting and continuous state.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA,
    ST_WDUMMY,
    ST_WBITS,
    ST_SKIP
  } qrd_state_e;

  typedef enum logic {
    RD_QUAD,
    RD_WORD
  } qrd_kind_e;

  localparam logic [7:0] OPC_QUAD_RD  = 8'hEB;
  localparam logic [7:0] OPC_WORD_RD  = 8'hE7;
  localparam logic [7:0] OPC_SET_WRAP = 8'h77;
  localparam logic [3:0] CONT_KEY     = 4'hA;

endpackage

// File: rtl/qrd_sync.sv
module qrd_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/qrd_wrap_unit.sv
module qrd_wrap_unit #(
  parameter int ADDR_W        = 24,
  parameter int WRAP_SEL_W    = 2,
  parameter int MIN_WRAP_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [WRAP_SEL_W:0]   load_bits,
  input  logic [ADDR_W-1:0]     cur_addr,
  output logic [ADDR_W-1:0]     next_addr,
  output logic [WRAP_SEL_W:0]   cfg
);

  localparam logic [WRAP_SEL_W:0] CFG_RESET = {{WRAP_SEL_W{1'b0}}, 1'b1};

  logic                  wrap_on;
  logic [WRAP_SEL_W-1:0] sel;
  logic [ADDR_W-1:0]     span_mask;
  logic [ADDR_W-1:0]     inc_addr;

  always_ff @(posedge clk) begin
    if (rst)       cfg <= CFG_RESET;
    else if (load) cfg <= load_bits;
  end

  assign wrap_on  = ~cfg[0];
  assign sel      = cfg[WRAP_SEL_W:1];
  assign inc_addr = cur_addr + ADDR_W'(1);

  always_comb begin
    span_mask = (ADDR_W'(1) << (MIN_WRAP_LOG2 + int'(sel))) - ADDR_W'(1);
    if (wrap_on) next_addr = (cur_addr & ~span_mask) | (inc_addr & span_mask);
    else         next_addr = inc_addr;
  end

endmodule

// File: rtl/qrd_ctrl.sv
module qrd_ctrl
  import qrd_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int LANES           = 4,
  parameter int BYTE_W          = 8,
  parameter int QUAD_DUMMY      = 4,
  parameter int WORD_DUMMY      = 2,
  parameter int WRAP_DUMMY_BITS = 24,
  parameter int WRAP_SEL_W      = 2,
  parameter int WRAP_FIELD_LSB  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_low,
  input  logic                sclk_rise,
  input  logic                sclk_fall,
  input  logic [LANES-1:0]    io_s,
  input  logic                qe,
  input  logic [BYTE_W-1:0]   mem_rdata,
  input  logic [ADDR_W-1:0]   next_addr,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic                wrap_load,
  output logic [WRAP_SEL_W:0] wrap_bits,
  output logic [LANES-1:0]    io_out,
  output logic [LANES-1:0]    io_oe,
  output qrd_state_e          state,
  output qrd_kind_e           kind,
  output logic                cont_q
);

  localparam int ADDR_NIBS = ADDR_W / LANES;
  localparam int BYTE_NIBS = BYTE_W / LANES;
  localparam int CNT_W     = $clog2(WRAP_DUMMY_BITS + ADDR_NIBS + BYTE_W + 1);
  localparam int NIB_W     = (BYTE_NIBS > 1) ? $clog2(BYTE_NIBS) : 1;
  localparam int FIELD_W   = WRAP_SEL_W + 1;
  localparam int FIELD_LO  = BYTE_W - 1 - (WRAP_FIELD_LSB + FIELD_W - 1);
  localparam int FIELD_HI  = BYTE_W - 1 - WRAP_FIELD_LSB;

  logic [CNT_W-1:0]        cnt;
  logic [BYTE_W-2:0]       opc_sh;
  logic [BYTE_W-1:0]       opc_in;
  logic [ADDR_W-LANES-1:0] addr_sh;
  logic [ADDR_W-1:0]       addr_in;
  logic                    hit_q;
  qrd_kind_e               cont_kind;
  logic [BYTE_W-1:0]       byte_q;
  logic [NIB_W-1:0]        nib_cnt;
  logic [CNT_W-1:0]        dummy_last;
  logic                    in_field;

  assign opc_in     = {opc_sh, io_s[0]};
  assign addr_in    = {addr_sh, io_s};
  assign dummy_last = (kind == RD_WORD) ? CNT_W'(WORD_DUMMY - 1) : CNT_W'(QUAD_DUMMY - 1);
  assign in_field   = (cnt >= CNT_W'(FIELD_LO)) && (cnt <= CNT_W'(FIELD_HI));

  always_ff @(posedge clk) begin
    wrap_load <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      opc_sh    <= '0;
      addr_sh   <= '0;
      cur_addr  <= '0;
      hit_q     <= 1'b0;
      cont_q    <= 1'b0;
      cont_kind <= RD_QUAD;
      kind      <= RD_QUAD;
      wrap_bits <= '0;
      byte_q    <= '0;
      nib_cnt   <= '0;
      io_out    <= '0;
      io_oe     <= '0;
    end else if (!cs_low) begin
      state <= ST_IDLE;
      cnt   <= '0;
      io_oe <= '0;
    end else if (state == ST_IDLE) begin
      cnt <= '0;
      if (cont_q) begin
        state <= ST_ADR;
        kind  <= cont_kind;
      end else begin
        state <= ST_OPC;
      end
    end else if (sclk_rise) begin
      cnt <= cnt + 1'b1;
      unique case (state)
        ST_OPC: begin
          opc_sh <= opc_in[BYTE_W-2:0];
          if (cnt == CNT_W'(BYTE_W - 1)) begin
            cnt <= '0;
            if ((opc_in == OPC_QUAD_RD || opc_in == OPC_WORD_RD) && qe) begin
              state <= ST_ADR;
              kind  <= (opc_in == OPC_WORD_RD) ? RD_WORD : RD_QUAD;
            end else if (opc_in == OPC_SET_WRAP) begin
              state <= ST_WDUMMY;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_ADR: begin
          addr_sh <= addr_in[ADDR_W-LANES-1:0];
          if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
            cnt      <= '0;
            state    <= ST_MODE;
            cur_addr <= (kind == RD_WORD) ? (addr_in & ~ADDR_W'(1)) : addr_in;
          end
        end
        ST_MODE: begin
          if (cnt == '0) hit_q <= (io_s == CONT_KEY);
          if (cnt == CNT_W'(BYTE_NIBS - 1)) begin
            cnt       <= '0;
            state     <= ST_DUMMY;
            cont_q    <= hit_q;
            cont_kind <= kind;
          end
        end
        ST_DUMMY: begin
          if (cnt == dummy_last) begin
            cnt     <= '0;
            nib_cnt <= '0;
            state   <= ST_DATA;
          end
        end
        ST_WDUMMY: begin
          if (cnt == CNT_W'(WRAP_DUMMY_BITS - 1)) begin
            cnt   <= '0;
            state <= ST_WBITS;
          end
        end
        ST_WBITS: begin
          if (in_field) wrap_bits <= {wrap_bits[FIELD_W-2:0], io_s[0]};
          if (cnt == CNT_W'(BYTE_W - 1)) begin
            wrap_load <= 1'b1;
            state     <= ST_SKIP;
          end
        end
        default: begin
        end
      endcase
    end else if (sclk_fall && state == ST_DATA) begin
      io_oe <= '1;
      if (nib_cnt == '0) begin
        io_out <= mem_rdata[BYTE_W-1 -: LANES];
        byte_q <= mem_rdata << LANES;
      end else begin
        io_out <= byte_q[BYTE_W-1 -: LANES];
        byte_q <= byte_q << LANES;
      end
      if (nib_cnt == NIB_W'(BYTE_NIBS - 1)) begin
        nib_cnt  <= '0;
        cur_addr <= next_addr;
      end else begin
        nib_cnt <= nib_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/qrd_quad_read_engine.sv
module qrd_quad_read_engine
  import qrd_pkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int LANES           = 4,
  parameter int BYTE_W          = 8,
  parameter int QUAD_DUMMY      = 4,
  parameter int WORD_DUMMY      = 2,
  parameter int WRAP_DUMMY_BITS = 24,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [LANES-1:0]  io_in,
  output logic [LANES-1:0]  io_out,
  output logic [LANES-1:0]  io_oe,
  input  logic              qe,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata
);

  localparam int WRAP_SEL_W = 2;
  localparam int SYNC_W     = LANES + 2;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, {LANES{1'b0}}};

  logic [SYNC_W-1:0]     sync_q;
  logic                  cs_s;
  logic                  sclk_s;
  logic                  sclk_d;
  logic [LANES-1:0]      io_s;
  logic [ADDR_W-1:0]     cur_addr;
  logic [ADDR_W-1:0]     next_addr;
  logic                  wrap_load;
  logic [WRAP_SEL_W:0]   wrap_bits;
  logic [WRAP_SEL_W:0]   wrap_cfg;
  qrd_state_e            state;
  qrd_kind_e             kind;
  logic                  cont_q;

  qrd_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, sclk, io_in}),
    .q   (sync_q)
  );

  assign {cs_s, sclk_s, io_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  qrd_ctrl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W),
    .QUAD_DUMMY(QUAD_DUMMY), .WORD_DUMMY(WORD_DUMMY),
    .WRAP_DUMMY_BITS(WRAP_DUMMY_BITS), .WRAP_SEL_W(WRAP_SEL_W),
    .WRAP_FIELD_LSB(4)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cs_low    (~cs_s),
    .sclk_rise (sclk_s & ~sclk_d),
    .sclk_fall (~sclk_s & sclk_d),
    .io_s      (io_s),
    .qe        (qe),
    .mem_rdata (mem_rdata),
    .next_addr (next_addr),
    .cur_addr  (cur_addr),
    .wrap_load (wrap_load),
    .wrap_bits (wrap_bits),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .state     (state),
    .kind      (kind),
    .cont_q    (cont_q)
  );

  qrd_wrap_unit #(.ADDR_W(ADDR_W), .WRAP_SEL_W(WRAP_SEL_W), .MIN_WRAP_LOG2(3)) wrap_i (
    .clk       (clk),
    .rst       (rst),
    .load      (wrap_load),
    .load_bits (wrap_bits),
    .cur_addr  (cur_addr),
    .next_addr (next_addr),
    .cfg       (wrap_cfg)
  );

  assign mem_addr = cur_addr;

endmodule

// File: rtl/qrd_checker.sv
module qrd_checker
  import qrd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              qe,
  input logic [LANES-1:0]  io_oe,
  input logic [ADDR_W-1:0] mem_addr,
  input qrd_state_e        state,
  input qrd_kind_e         kind,
  input logic              cont_q,
  input logic [2:0]        wrap_cfg
);

  logic [ADDR_W-1:0] win_mask;
  assign win_mask = (ADDR_W'(8) << wrap_cfg[2:1]) - ADDR_W'(1);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wrap_cfg[0] && !cont_q && io_oe == '0));

  p_word_even_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MODE && $past(state) == ST_ADR && kind == RD_WORD) |-> !mem_addr[0]);

  p_linear_step_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && $past(state) == ST_DATA && wrap_cfg[0] && mem_addr != $past(mem_addr))
    |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

  p_cont_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADR && $past(state) == ST_IDLE) |-> $past(cont_q));

  p_qe_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADR && $past(state) == ST_OPC) |-> $past(qe));

  p_wrap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && $past(state) == ST_DATA && !wrap_cfg[0])
    |-> ((mem_addr ^ $past(mem_addr)) & ~win_mask) == '0);

  p_oe_shape_r12: assert property (@(posedge clk) disable iff (rst)
    (io_oe == '0) || (io_oe == '1));

endmodule

bind qrd_quad_read_engine qrd_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .qe       (qe),
  .io_oe    (io_oe),
  .mem_addr (mem_addr),
  .state    (state),
  .kind     (kind),
  .cont_q   (cont_q),
  .wrap_cfg (wrap_cfg)
);

// File: tb/qrd_quad_read_engine_tb.sv
`timescale 1ns/1ps
module qrd_quad_read_engine_tb_top;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n;
  logic        sclk;
  logic [3:0]  io_in;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic        qe;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;

  int n_checks = 0;
  int n_err    = 0;
  int cs_hi    = 0;

  bit       m_cont      = 1'b0;
  bit       m_cont_word = 1'b0;
  bit [2:0] m_wrap      = 3'b001;

  always #2.5 clk = ~clk;

  qrd_quad_read_engine dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .qe(qe), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(posedge clk) mem_rdata <= pat(mem_addr);

  function automatic logic [23:0] nxt(input logic [23:0] a);
    int len, base;
    if (m_wrap[0]) return a + 24'd1;
    len  = 8 << m_wrap[2:1];
    base = int'(a) - (int'(a) % len);
    return 24'(base + ((int'(a) - base + 1) % len));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic spi_cycle(input logic [3:0] nib, output logic [3:0] d, output logic [3:0] oe);
    io_in = nib;
    repeat (HALF) @(negedge clk);
    d  = io_out;
    oe = io_oe;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic spi_tx(input logic [3:0] nib);
    logic [3:0] d, oe;
    spi_cycle(nib, d, oe);
  endtask

  task automatic send_single(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_tx({3'b000, b[i]});
  endtask

  task automatic cs_end();
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic quad_read(input logic [7:0] opc, input bit send_opc, input logic [23:0] addr,
                           input logic [7:0] mode, input int nbytes, input bit drive, input string req);
    bit word;
    logic [23:0] a;
    logic [7:0]  ev;
    logic [3:0]  en, d, oe;
    word = send_opc ? (opc == 8'hE7) : m_cont_word;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    if (send_opc) send_single(opc);
    for (int i = 5; i >= 0; i--) spi_tx(addr[i*4 +: 4]);
    spi_tx(mode[7:4]);
    spi_tx(mode[3:0]);
    for (int i = 0; i < (word ? 2 : 4); i++) spi_tx(4'h0);
    a = word ? {addr[23:1], 1'b0} : addr;
    for (int b = 0; b < nbytes; b++) begin
      ev = pat(a);
      for (int n = 0; n < 2; n++) begin
        spi_cycle(4'h0, d, oe);
        en = (n == 0) ? ev[7:4] : ev[3:0];
        if (drive) chk(d == en && oe == 4'hF, req, {24'h0, oe, d}, {24'h0, 4'hF, en});
        else       chk(oe == 4'h0, req, {28'h0, oe}, 32'h0);
      end
      a = nxt(a);
    end
    cs_end();
    if (drive) begin
      m_cont      = (mode[7:4] == 4'hA);
      m_cont_word = word;
    end
  endtask

  task automatic set_wrap(input logic [7:0] wb);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    send_single(8'h77);
    for (int i = 0; i < 24; i++) spi_tx(4'h0);
    send_single(wb);
    cs_end();
    m_wrap = wb[6:4];
  endtask

  // R12: enable shape and release after chip select, every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n) cs_hi++;
      else      cs_hi = 0;
      chk(io_oe == 4'h0 || io_oe == 4'hF, "R12 oe shape", {28'h0, io_oe}, 32'hF);
      if (cs_hi > 4) chk(io_oe == 4'h0, "R12 oe off", {28'h0, io_oe}, 32'h0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; io_in = 4'h0; qe = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(io_oe == 4'h0, "R1 reset oe", {28'h0, io_oe}, 32'h0);

    qe = 1'b1;
    // R1/R2/R4: first read needs opcode, linear across a page
    quad_read(8'hEB, 1'b1, 24'h0000FC, 8'h00, 8, 1'b1, "R2 R4 linear page cross");
    quad_read(8'hEB, 1'b1, 24'hFFFFFE, 8'h00, 4, 1'b1, "R4 top rollover");
    // R3: word read, odd address forced even
    quad_read(8'hE7, 1'b1, 24'h012345, 8'hFF, 4, 1'b1, "R3 word read");
    // R7: quad enable off
    qe = 1'b0;
    quad_read(8'hEB, 1'b1, 24'h000400, 8'hA0, 2, 1'b0, "R7 qe off ignored");
    qe = 1'b1;
    quad_read(8'hEB, 1'b1, 24'h000410, 8'h00, 2, 1'b1, "R7 cont unchanged");
    // R5/R6: continuous mode with EB
    quad_read(8'hEB, 1'b1, 24'h00A000, 8'hA5, 3, 1'b1, "R5 set cont");
    quad_read(8'hEB, 1'b0, 24'h00B123, 8'h5A, 3, 1'b1, "R5 no opcode");
    quad_read(8'hEB, 1'b1, 24'h00C000, 8'h00, 3, 1'b1, "R6 opcode again");
    // R5/R3: continuous mode with E7
    quad_read(8'hE7, 1'b1, 24'h020000, 8'hA0, 2, 1'b1, "R5 set cont word");
    quad_read(8'hE7, 1'b0, 24'h020101, 8'h00, 3, 1'b1, "R5 R3 cont word");
    quad_read(8'hEB, 1'b1, 24'h020200, 8'h00, 2, 1'b1, "R6 after word");
    // R11: unknown opcode
    quad_read(8'h03, 1'b1, 24'h000000, 8'h00, 2, 1'b0, "R11 other opcode");
    quad_read(8'hEB, 1'b1, 24'h000033, 8'h00, 2, 1'b1, "R11 recovery");
    // R8/R9: all wrap lengths, qe off during set
    for (int s = 0; s < 4; s++) begin
      qe = (s != 1);
      set_wrap({1'b0, 2'(s), 1'b0, 4'h0});
      qe = 1'b1;
      quad_read(8'hEB, 1'b1, 24'h0201F5, 8'h00, (8 << s) + 4, 1'b1, "R8 R9 wrap EB");
    end
    set_wrap(8'h00);
    quad_read(8'hE7, 1'b1, 24'h003007, 8'h00, 6, 1'b1, "R9 wrap E7");
    // R10: wrap off restores linear reads
    set_wrap(8'h10);
    quad_read(8'hEB, 1'b1, 24'h0000FA, 8'h00, 10, 1'b1, "R10 linear again");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule